// File: doc/BRIEF.md
# Flash Row-Erase Controller with Key Unlock

This block lets software erase one row of on-chip program flash through a small register window. Software loads a 15-bit word address as a low byte and a high byte, chooses between the main program array and the user-ID area, and writes a control byte that asks for an erase with writes enabled. The start request counts only when a two-write key (0x55, then 0xAA) has just been written to a dedicated key register. Any other access in between cancels the key.

An accepted request is checked against a write-protected boot area. If the row is not protected, the block latches the row index and region, pulses an erase strobe towards the flash array and holds a CPU-stall output for a fixed, parameterised number of cycles. When the erase ends, a sticky done flag is set. An interrupt output follows that flag when the interrupt-enable bit is set. Starting an erase never touches the address, region or enable bits. No erase is ever started by anything other than this sequence.

Top module: `flash_row_eraser`

## Requirements
- R1: After reset, all four registers read 0x00, and `cpu_stall`, `irq` and `fl_erase_strobe` are 0.
- R2: Register 0 holds address bits [7:0] and register 1 holds address bits [14:8] in its bits [6:0]. Bit 7 of register 1 reads 0. The erased row is address[14:5] (32 words per row), presented on `fl_erase_row`.
- R3: A control write (register 2) with bit 0 (start) set is accepted only if the two bus accesses just before it were writes of 0x55 and then 0xAA to register 3. Idle cycles may fall between these accesses. Any other read or write breaks the key. A start that is not accepted causes no strobe and no stall, and bit 0 reads 0.
- R4: An accepted start also needs bit 1 (write enable) and bit 2 (erase select) set in the same control write. Otherwise no erase takes place.
- R5: In the main array (bit 3 = 0), rows below WP_ROWS (default 4, i.e. addresses below 0x0080) are protected. A start aimed at them is dropped: there is no strobe and no stall, done is not set and bit 0 reads 0. The user-ID area (bit 3 = 1) has no protection.
- R6: An accepted start gives a one-cycle `fl_erase_strobe` in the first cycle after the write, with `fl_erase_row` and `fl_erase_region` showing the target. `cpu_stall` is high for exactly ERASE_CYCLES cycles starting in that same cycle.
- R7: Control bit 0 reads 1 while the erase runs and returns to 0 when it ends. On that same edge, bit 4 (done) is set. Done stays set until a control write with bit 4 = 0 clears it. If completion and a clear fall on the same edge, completion wins.
- R8: `irq` is high exactly when done is set and bit 5 (interrupt enable) is set.
- R9: An erase leaves the address registers and control bits 1, 2, 3 and 5 unchanged.
- R10: A start issued while an erase is running is ignored, even after a valid key. The running erase keeps its length and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read also breaks the key) |
| bus_addr | input | 2 | Register index: 0 addr low, 1 addr high, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the register state |
| fl_erase_strobe | output | 1 | One-cycle erase command to the flash array |
| fl_erase_row | output | ROW_W | Row index being erased |
| fl_erase_region | output | 1 | 0 main array, 1 user-ID area |
| cpu_stall | output | 1 | High while an erase runs |
| irq | output | 1 | Done flag gated by interrupt enable |

## Verification
The strobe and the rising stall follow the accepting control write by one edge. The stall then falls, and done sets, ERASE_CYCLES edges after that. Register read data is valid in the same cycle as the read strobe, and `irq` follows done with no added delay. The bench runs a behavioural model that advances on each rising edge from the same bus inputs. Away from that edge, it compares strobe, stall, interrupt and row target against the model every cycle, so each result is checked in exactly the cycle it is due. Register reads are sampled shortly after the read strobe is applied.

// File: rtl/fre_pkg.sv
// Package: shared register indices, control bit positions, key values
// and the key-tracking state type for the flash row-erase controller.
package fre_pkg;
    localparam logic [1:0] REG_ADDR_LO = 2'd0;
    localparam logic [1:0] REG_ADDR_HI = 2'd1;
    localparam logic [1:0] REG_CTRL    = 2'd2;
    localparam logic [1:0] REG_KEY     = 2'd3;

    localparam int B_GO     = 0;
    localparam int B_WEN    = 1;
    localparam int B_ERS    = 2;
    localparam int B_REGION = 3;
    localparam int B_DONE   = 4;
    localparam int B_IRQEN  = 5;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_HALF  = 2'd1,
        KS_ARMED = 2'd2
    } key_state_t;
endpackage

// File: rtl/fre_unlock.sv
// Module: fre_unlock
// Tracks the two-write key on the key register. The output is high only
// right after 0x55 then 0xAA were written with no other access between
// them. Any other bus access drops it back to idle.
// Assumes: at most one of bus_wr / bus_rd is high in a cycle.
module fre_unlock
    import fre_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic       armed
);
    key_state_t state_q, state_d;
    logic key_wr;

    assign key_wr = bus_wr && (bus_addr == REG_KEY);

    // Next-state choice for the key sequence.
    always_comb begin
        state_d = state_q;
        if (key_wr && bus_wdata == KEY_FIRST && state_q == KS_IDLE)
            state_d = KS_HALF;
        else if (key_wr && bus_wdata == KEY_SECOND && state_q == KS_HALF)
            state_d = KS_ARMED;
        else if (bus_wr || bus_rd)
            state_d = KS_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == KS_ARMED);

    AST_FOREIGN_ACCESS_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !key_wr) |=> !armed); // R3
    AST_ARM_AFTER_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_wr && bus_wdata == KEY_SECOND)); // R3
endmodule

// File: rtl/fre_sequencer.sv
// Module: fre_sequencer
// Runs one erase. It latches the target row and region, pulses the strobe,
// holds busy for ERASE_CYCLES cycles and sets a sticky done flag at the end.
// Assumes: start is only raised while not busy; ERASE_CYCLES >= 1.
module fre_sequencer #(
    parameter int ROW_W        = 10,
    parameter int ERASE_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr_done,
    input  logic [ROW_W-1:0] row_in,
    input  logic             region_in,
    output logic             busy,
    output logic             strobe,
    output logic             done,
    output logic [ROW_W-1:0] row,
    output logic             region
);
    localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = busy && (cnt_q == '0);

    // Busy window and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_LOAD;
        end else if (last) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Target latch and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            row    <= '0;
            region <= 1'b0;
        end else begin
            strobe <= start;
            if (start) begin
                row    <= row_in;
                region <= region_in;
            end
        end
    end

    // Sticky done flag; completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (last)     done <= 1'b1;
        else if (clr_done) done <= 1'b0;
    end

    AST_STROBE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10
endmodule

// File: rtl/flash_row_eraser.sv
// Module: flash_row_eraser (top)
// Holds the register window, qualifies the start request with the key,
// the enable bits and the write-protect window, and drives the sequencer.
// Assumes: single-cycle register accesses; read data is combinational.
module flash_row_eraser
    import fre_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int ROW_WORDS    = 32,
    parameter int WP_ROWS      = 4,
    parameter int ERASE_CYCLES = 20,
    localparam int ROW_LSB     = $clog2(ROW_WORDS),
    localparam int ROW_W       = ADDR_W - ROW_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             fl_erase_strobe,
    output logic [ROW_W-1:0] fl_erase_row,
    output logic             fl_erase_region,
    output logic             cpu_stall,
    output logic             irq
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0]        addr_lo_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic              wen_q, ers_q, region_q, irqen_q;
    logic              armed, busy, done;
    logic              ctrl_wr, start_req, wp_hit, start_ok, clr_done;
    logic [ADDR_W-1:0] full_addr;
    logic [ROW_W-1:0]  tgt_row;

    assign full_addr = {addr_hi_q, addr_lo_q};
    assign tgt_row   = full_addr[ADDR_W-1:ROW_LSB];
    assign ctrl_wr   = bus_wr && (bus_addr == REG_CTRL);
    assign start_req = ctrl_wr && bus_wdata[B_GO] && bus_wdata[B_WEN]
                       && bus_wdata[B_ERS] && armed && !busy;
    assign wp_hit    = !bus_wdata[B_REGION] && (tgt_row < ROW_W'(WP_ROWS));
    assign start_ok  = start_req && !wp_hit;
    assign clr_done  = ctrl_wr && !bus_wdata[B_DONE];

    // Address byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else if (bus_wr && bus_addr == REG_ADDR_LO) begin
            addr_lo_q <= bus_wdata;
        end else if (bus_wr && bus_addr == REG_ADDR_HI) begin
            addr_hi_q <= bus_wdata[HI_W-1:0];
        end
    end

    // Control bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q    <= 1'b0;
            ers_q    <= 1'b0;
            region_q <= 1'b0;
            irqen_q  <= 1'b0;
        end else if (ctrl_wr) begin
            wen_q    <= bus_wdata[B_WEN];
            ers_q    <= bus_wdata[B_ERS];
            region_q <= bus_wdata[B_REGION];
            irqen_q  <= bus_wdata[B_IRQEN];
        end
    end

    fre_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    fre_sequencer #(
        .ROW_W        (ROW_W),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .clr_done  (clr_done),
        .row_in    (tgt_row),
        .region_in (bus_wdata[B_REGION]),
        .busy      (busy),
        .strobe    (fl_erase_strobe),
        .done      (done),
        .row       (fl_erase_row),
        .region    (fl_erase_region)
    );

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            REG_ADDR_LO: bus_rdata = addr_lo_q;
            REG_ADDR_HI: bus_rdata = 8'(addr_hi_q);
            REG_CTRL:    bus_rdata = {2'b00, irqen_q, done, region_q, ers_q, wen_q, busy};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign cpu_stall = busy;
    assign irq       = done && irqen_q;

    AST_UNARMED_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[B_GO] && !armed && !busy) |=> !busy); // R3
    AST_WP_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && wp_hit) |=> (!busy && !fl_erase_strobe)); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irqen_q); // R8
    AST_WEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctrl_wr)) |-> $stable(wen_q)); // R9
endmodule

// File: tb/flash_row_eraser_bench.sv
// Bench: behavioural reference model advanced on each rising edge,
// compared against the outputs on every falling edge, plus register reads.
module flash_row_eraser_bench;
    localparam int ERASE_CYCLES = 20;
    localparam int WP_ROWS      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       fl_erase_strobe, fl_erase_region, cpu_stall, irq;
    logic [9:0] fl_erase_row;

    int total = 0, bad = 0, cyc = 0;

    // Reference model state.
    int m_lo, m_hi, m_wen, m_ers, m_reg, m_ien, m_done, m_key, m_left;
    int m_strobe, m_row, m_treg;

    always #10 clk = ~clk;   // 50 MHz

    flash_row_eraser #(.ERASE_CYCLES(ERASE_CYCLES), .WP_ROWS(WP_ROWS)) u_flash_row_eraser (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_erase_strobe(fl_erase_strobe), .fl_erase_row(fl_erase_row),
        .fl_erase_region(fl_erase_region), .cpu_stall(cpu_stall), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Model: follows the requirements on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_wen = 0; m_ers = 0; m_reg = 0; m_ien = 0;
            m_done = 0; m_key = 0; m_left = 0; m_strobe = 0; m_row = 0; m_treg = 0;
        end else begin
            bit accept;
            accept = bus_wr && bus_addr == 2 && bus_wdata[0] && bus_wdata[1] && bus_wdata[2]
                     && m_key == 2 && m_left == 0;
            if (accept && !bus_wdata[3] && ((m_hi * 256 + m_lo) / 32) < WP_ROWS) accept = 0;
            m_strobe = accept;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_done = 2;  // marks completion this edge
            end
            if (bus_wr && bus_addr == 2 && !bus_wdata[4] && m_done != 2) m_done = 0;
            if (m_done == 2) m_done = 1;
            if (accept) begin
                m_left = ERASE_CYCLES;
                m_row  = (m_hi * 256 + m_lo) / 32;
                m_treg = bus_wdata[3];
            end
            if (bus_wr && bus_addr == 0) m_lo = bus_wdata;
            if (bus_wr && bus_addr == 1) m_hi = bus_wdata & 8'h7F;
            if (bus_wr && bus_addr == 2) begin
                m_wen = bus_wdata[1]; m_ers = bus_wdata[2];
                m_reg = bus_wdata[3]; m_ien = bus_wdata[5];
            end
            if (bus_wr && bus_addr == 3 && bus_wdata == 8'h55 && m_key == 0) m_key = 1;
            else if (bus_wr && bus_addr == 3 && bus_wdata == 8'hAA && m_key == 1) m_key = 2;
            else if (bus_wr || bus_rd) m_key = 0;
        end
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 strobe", fl_erase_strobe, m_strobe);
            check("R6 stall", cpu_stall, m_left > 0);
            check("R8 irq", irq, m_done && m_ien);
            if (m_strobe) begin
                check("R2 row", fl_erase_row, m_row);
                check("R6 region", fl_erase_region, m_treg);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return (m_ien << 5) | (m_done << 4) | (m_reg << 3) | (m_ers << 2)
                      | (m_wen << 1) | (m_left > 0 ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic rd(input string req, input int a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'(a);
        #1;
        check(req, bus_rdata, model_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(3, 8'h55);
        wr(3, 8'hAA);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && cpu_stall; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        rd("R1 lo", 0); rd("R1 hi", 1); rd("R1 ctrl", 2); rd("R1 key", 3);
        // R2: address bytes, top bit of high byte dropped
        wr(1, 8'hFF); rd("R2 hi mask", 1);
        wr(0, 8'h23); wr(1, 8'h01); rd("R2 lo", 0); rd("R2 hi", 1);
        // R3: start without key
        wr(2, 8'h07); rd("R3 no key", 2);
        // R3: key broken by a read
        wr(3, 8'h55); rd("R3 broken key read", 0); wr(3, 8'hAA); wr(2, 8'h07);
        rd("R3 broken key", 2);
        // R3: wrong second key
        wr(3, 8'h55); wr(3, 8'h55); wr(2, 8'h07); rd("R3 wrong key", 2);
        // R4: erase select missing, then write enable missing
        unlock(); wr(2, 8'h03); rd("R4 no erase select", 2);
        unlock(); wr(2, 8'h05); rd("R4 no write enable", 2);
        // R6/R7/R8: accepted erase with interrupt enabled
        unlock(); wr(2, 8'h27);
        rd("R7 busy reads 1", 2);
        wait_idle();
        rd("R7 done set", 2);
        rd("R9 lo kept", 0); rd("R9 hi kept", 1);
        check("R8 irq high", irq, 1);
        // R7: clear done by writing bit 4 = 0
        wr(2, 8'h26); rd("R7 done cleared", 2);
        check("R8 irq low", irq, 0);
        // R5: protected row 2 of main array
        wr(0, 8'h40); wr(1, 8'h00);
        unlock(); wr(2, 8'h07); rd("R5 protected", 2);
        check("R5 no stall", cpu_stall, 0);
        // R5: same row in user-ID area is allowed; R10: restart while busy
        unlock(); wr(2, 8'h0F);
        rd("R5 user id busy", 2);
        unlock(); wr(2, 8'h0F);
        wait_idle();
        rd("R10 single erase done", 2);
        // R8: done with interrupt disabled
        check("R8 irq masked", irq, 0);
        // R6: another main-array row, top of array
        wr(2, 8'h06);
        wr(0, 8'hE0); wr(1, 8'h7F);
        unlock(); wr(2, 8'h07);
        wait_idle();
        rd("R9 ctrl kept", 2);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule